// File: doc/BRIEF.md
# Optimal Threshold Search Sequencer

This block trains one learning neuron. Samples, each an unsigned value with a one-bit class label, are first written into a local sample memory. A start pulse begins a run. The run visits a fixed set of candidate transformation functions in index order. For each function, the sequencer transforms every sample into an intermediate memory. It then tries each transformed value as a threshold and gives each threshold a deficiency score. The score counts the samples that sit on the minority side of their class, so lower is better. The sequencer keeps the best threshold of the function. It then compares that threshold's score with the best score of all earlier functions.

When a function strictly improves on everything before it, the sequencer updates the global best threshold, score and function index. It also copies the function's transformed samples into a result memory, which the host can read through a separate read port. When the last function has been handled, a one-cycle done pulse marks the end of the run. The cycle cost of each step is fixed by parameters: a number of clocks per sample for the transform, and per-sample clocks plus a fixed overhead for each threshold. A run therefore has an exact, predictable length.

Top module: `thresh_search_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0, `best_score` is all ones, and `best_thr` and `best_func` are 0.
- R2: Transform function k maps a sample x (DW bits, results truncated to DW bits) as follows: k=0 gives x; k=1 gives ~x; k=2 gives x>>1; k=3 gives x XOR 0x55 (alternating bits, bit 0 set); k=4 gives 3*x; k=5 rotates x left by one; k=6 gives x+1. The functions are visited from 0 to NFUNC-1.
- R3: For a threshold t, a sample lies above when its transformed value is >= t and below otherwise. The score is min(ones, zeros) among the samples above, plus min(ones, zeros) among the samples below. Only transformed sample values of the current function are tried as thresholds.
- R4: Improvement is strict. On equal scores, the earlier threshold (lower sample index) within a function is kept, and so is the earlier function.
- R5: When `done` pulses, `best_thr`, `best_score` and `best_func` hold the lowest score over all functions and thresholds, with its threshold and function. They hold these values until the next start.
- R6: After `done`, result-memory word i (i < n) holds the winning function's transform of sample i. The result memory is written only when a function strictly improves the global best.
- R7: With n samples, each function takes XF_CYC*n + n*(OVH_CYC + SC_CYC*n) + 1 cycles, plus n more when its results are copied. `done` rises that many total cycles after the clock edge that samples `start`.
- R8: `busy` is high from the cycle after the accepted start until `done`. `done` lasts one cycle, and `busy` is low while `done` is high.
- R9: A `start` pulse while `busy` is high is ignored.
- R10: `n_samp` (1 to DEPTH) is captured at start. Changing it during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_we | input | 1 | Sample memory write enable |
| ld_addr | input | AW | Sample memory write address |
| ld_value | input | DW | Sample value |
| ld_class | input | 1 | Sample class label |
| n_samp | input | CW | Number of samples used by the run |
| start | input | 1 | Start pulse |
| busy | output | 1 | Training in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| best_thr | output | DW | Best threshold found |
| best_score | output | CW | Deficiency score of best threshold |
| best_func | output | FW | Index of winning function |
| rd_addr | input | AW | Result memory read address |
| rd_data | output | DW | Result memory read data |

## Verification
The hardest behaviour to reach from the ports is a later function beating an earlier one. That later win forces a second copy into the result memory and lengthens the run by n cycles. The bench uses a sample set whose classes follow bit 6 of the value. Such a set separates cleanly only after the rotate function moves that bit to the top, so the win appears late in the run. All-tie sets exercise the opposite case, where function 0 must win and only one copy takes place. A mid-run start pulse with a changed sample count shows, through the measured run length and the results, that neither has any effect.

// File: rtl/tss_pkg.sv
// Package: shared state encoding for the threshold search sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package tss_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_XF    = 3'd1,
        S_OVH   = 3'd2,
        S_SMP   = 3'd3,
        S_SCORE = 3'd4,
        S_UPD   = 3'd5,
        S_MOVE  = 3'd6
    } tss_state_e;
endpackage

// File: rtl/tss_ram.sv
// Module: simple memory with one synchronous write port and NRD
// combinational read ports.
// Assumes: addresses are below DEPTH; contents are not reset.
module tss_ram #(
    parameter int DW    = 8,
    parameter int DEPTH = 1024,
    parameter int NRD   = 1
) (
    input  logic                                  clk,
    input  logic                                  we,
    input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] waddr,
    input  logic [DW-1:0]                         wdata,
    input  logic [NRD-1:0][((DEPTH>1)?$clog2(DEPTH):1)-1:0] raddr,
    output logic [NRD-1:0][DW-1:0]                rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store one word per cycle when enabled.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // One asynchronous read path per requested port.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end
endmodule

// File: rtl/tss_xform.sv
// Module: combinational bank of candidate transformation functions.
// Assumes: fsel below 7; other codes pass the value through.
module tss_xform #(
    parameter int DW = 8
) (
    input  logic [2:0]    fsel,
    input  logic [DW-1:0] x,
    output logic [DW-1:0] y
);
    logic [DW-1:0] pat;

    // Alternating mask with bit 0 set.
    for (genvar b = 0; b < DW; b++) begin : g_pat
        assign pat[b] = (b % 2 == 0);
    end

    // Select the transform for the current function index.
    always_comb begin
        case (fsel)
            3'd0:    y = x;
            3'd1:    y = ~x;
            3'd2:    y = x >> 1;
            3'd3:    y = x ^ pat;
            3'd4:    y = x + (x << 1);
            3'd5:    y = {x[DW-2:0], x[DW-1]};
            3'd6:    y = x + DW'(1);
            default: y = x;
        endcase
    end
endmodule

// File: rtl/tss_scorer.sv
// Module: per-threshold class counters and deficiency score.
// Assumes: clr is held before a threshold is scanned; at most 2**CW-1
// samples are accumulated.
module tss_scorer #(
    parameter int DW = 8,
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          acc,
    input  logic [DW-1:0] thr,
    input  logic [DW-1:0] y,
    input  logic          cls,
    output logic [CW-1:0] score
);
    logic [CW-1:0] hi1, hi0, lo1, lo0;
    logic [CW-1:0] min_hi, min_lo;

    // Count class labels on each side of the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hi1 <= '0; hi0 <= '0; lo1 <= '0; lo0 <= '0;
        end else if (acc) begin
            if (y >= thr) begin
                if (cls) hi1 <= hi1 + CW'(1);
                else     hi0 <= hi0 + CW'(1);
            end else begin
                if (cls) lo1 <= lo1 + CW'(1);
                else     lo0 <= lo0 + CW'(1);
            end
        end
    end

    // Minority count per side, summed.
    always_comb begin
        min_hi = (hi1 < hi0) ? hi1 : hi0;
        min_lo = (lo1 < lo0) ? lo1 : lo0;
        score  = min_hi + min_lo;
    end

    AST_ACC_NOT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (score == '0)) else $error("score not cleared"); // R3
endmodule

// File: rtl/thresh_search_seq.sv
// Module: training sequencer. Runs each function as transform, threshold
// scan, global update and a copy that happens only when the function wins.
// Assumes: n_samp in 1..DEPTH at start; OVH_CYC >= 2; NFUNC <= 7.
module thresh_search_seq
    import tss_pkg::*;
#(
    parameter int DW      = 8,
    parameter int DEPTH   = 1024,
    parameter int NFUNC   = 7,
    parameter int XF_CYC  = 16,
    parameter int SC_CYC  = 4,
    parameter int OVH_CYC = 7,
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int FW     = (NFUNC > 1) ? $clog2(NFUNC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_value,
    input  logic          ld_class,
    input  logic [CW-1:0] n_samp,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] best_thr,
    output logic [CW-1:0] best_score,
    output logic [FW-1:0] best_func,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int MAXC = (XF_CYC > SC_CYC) ? ((XF_CYC > OVH_CYC) ? XF_CYC : OVH_CYC)
                                             : ((SC_CYC > OVH_CYC) ? SC_CYC : OVH_CYC);
    localparam int CNTW = $clog2(MAXC + 1);

    tss_state_e    state;
    logic [CW-1:0] n_lat;
    logic [FW-1:0] fidx;
    logic [AW-1:0] si, tj;
    logic [CNTW-1:0] cyc;
    logic [DW-1:0] thr_reg, fb_thr;
    logic [CW-1:0] fb_score;

    logic [0:0][AW-1:0]   s_raddr;
    logic [0:0][DW:0]     s_rdata;
    logic [1:0][AW-1:0]   i_raddr;
    logic [1:0][DW-1:0]   i_rdata;
    logic [0:0][AW-1:0]   r_raddr;
    logic [0:0][DW-1:0]   r_rdata;
    logic [DW-1:0] xf_y;
    logic [CW-1:0] sc_score;
    logic xf_last, sc_last, ovh_last, last_i, last_j, last_f;
    logic imem_we, rmem_we;

    // Cycle-position and index-end decodes.
    always_comb begin
        xf_last  = (cyc == CNTW'(XF_CYC - 1));
        sc_last  = (cyc == CNTW'(SC_CYC - 1));
        ovh_last = (cyc == CNTW'(OVH_CYC - 2));
        last_i   = (CW'(si) == n_lat - CW'(1));
        last_j   = (CW'(tj) == n_lat - CW'(1));
        last_f   = (int'(fidx) == NFUNC - 1);
        imem_we  = (state == S_XF) && xf_last;
        rmem_we  = (state == S_MOVE);
        s_raddr[0] = si;
        i_raddr[0] = tj;
        i_raddr[1] = si;
        r_raddr[0] = rd_addr;
        rd_data    = r_rdata[0];
        busy       = (state != S_IDLE);
    end

    tss_ram #(.DW(DW + 1), .DEPTH(DEPTH), .NRD(1)) u_smem (
        .clk(clk), .we(ld_we), .waddr(ld_addr), .wdata({ld_class, ld_value}),
        .raddr(s_raddr), .rdata(s_rdata));

    tss_ram #(.DW(DW), .DEPTH(DEPTH), .NRD(2)) u_imem (
        .clk(clk), .we(imem_we), .waddr(si), .wdata(xf_y),
        .raddr(i_raddr), .rdata(i_rdata));

    tss_ram #(.DW(DW), .DEPTH(DEPTH), .NRD(1)) u_rmem (
        .clk(clk), .we(rmem_we), .waddr(si), .wdata(i_rdata[1]),
        .raddr(r_raddr), .rdata(r_rdata));

    tss_xform #(.DW(DW)) u_xf (
        .fsel(3'(fidx)), .x(s_rdata[0][DW-1:0]), .y(xf_y));

    tss_scorer #(.DW(DW), .CW(CW)) u_sc (
        .clk(clk), .rst_n(rst_n), .clr(state == S_OVH),
        .acc((state == S_SMP) && sc_last), .thr(thr_reg),
        .y(i_rdata[1]), .cls(s_rdata[0][DW]), .score(sc_score));

    // Main sequencer: nested function / threshold / sample loops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            n_lat      <= '0;
            fidx       <= '0;
            si         <= '0;
            tj         <= '0;
            cyc        <= '0;
            thr_reg    <= '0;
            fb_thr     <= '0;
            fb_score   <= '1;
            best_thr   <= '0;
            best_score <= '1;
            best_func  <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        n_lat      <= n_samp;
                        fidx       <= '0;
                        si         <= '0;
                        cyc        <= '0;
                        best_thr   <= '0;
                        best_score <= '1;
                        best_func  <= '0;
                        state      <= S_XF;
                    end
                end
                S_XF: begin
                    if (xf_last) begin
                        cyc <= '0;
                        if (last_i) begin
                            si       <= '0;
                            tj       <= '0;
                            fb_score <= '1;
                            fb_thr   <= '0;
                            state    <= S_OVH;
                        end else begin
                            si <= si + AW'(1);
                        end
                    end else begin
                        cyc <= cyc + CNTW'(1);
                    end
                end
                S_OVH: begin
                    thr_reg <= i_rdata[0];
                    if (ovh_last) begin
                        cyc   <= '0;
                        si    <= '0;
                        state <= S_SMP;
                    end else begin
                        cyc <= cyc + CNTW'(1);
                    end
                end
                S_SMP: begin
                    if (sc_last) begin
                        cyc <= '0;
                        if (last_i) state <= S_SCORE;
                        else        si <= si + AW'(1);
                    end else begin
                        cyc <= cyc + CNTW'(1);
                    end
                end
                S_SCORE: begin
                    if (sc_score < fb_score) begin
                        fb_score <= sc_score;
                        fb_thr   <= thr_reg;
                    end
                    cyc <= '0;
                    if (last_j) begin
                        state <= S_UPD;
                    end else begin
                        tj    <= tj + AW'(1);
                        state <= S_OVH;
                    end
                end
                S_UPD: begin
                    si  <= '0;
                    cyc <= '0;
                    if (fb_score < best_score) begin
                        best_score <= fb_score;
                        best_thr   <= fb_thr;
                        best_func  <= fidx;
                        state      <= S_MOVE;
                    end else if (last_f) begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end else begin
                        fidx  <= fidx + FW'(1);
                        state <= S_XF;
                    end
                end
                S_MOVE: begin
                    if (last_i) begin
                        si <= '0;
                        if (last_f) begin
                            done  <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            fidx  <= fidx + FW'(1);
                            state <= S_XF;
                        end
                    end else begin
                        si <= si + AW'(1);
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("busy during done"); // R8
    AST_BEST_NONINCR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (best_score <= $past(best_score)))
        else $error("best score rose within a run"); // R5
    AST_SCORE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (best_score <= n_lat)) else $error("score above count"); // R3
    AST_FUNC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(best_func) < NFUNC)) else $error("function out of range"); // R2
    AST_NLAT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(n_lat)) else $error("count changed"); // R10
    AST_MOVE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        rmem_we |-> (best_func == fidx)) else $error("copy by non-winner"); // R6
endmodule

// File: tb/sim_thresh_search_seq.sv
module sim_thresh_search_seq;
    localparam int DW = 8;
    localparam int DEPTH = 1024;
    localparam int AW = 10;
    localparam int CW = 11;
    localparam int FW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_value = '0;
    logic ld_class = 1'b0;
    logic [CW-1:0] n_samp = '0;
    logic start = 1'b0;
    logic busy, done;
    logic [DW-1:0] best_thr;
    logic [CW-1:0] best_score;
    logic [FW-1:0] best_func;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;

    always #2 clk = ~clk;

    thresh_search_seq u0 (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_value(ld_value), .ld_class(ld_class), .n_samp(n_samp),
        .start(start), .busy(busy), .done(done), .best_thr(best_thr),
        .best_score(best_score), .best_func(best_func),
        .rd_addr(rd_addr), .rd_data(rd_data));

    typedef struct packed {
        int thr;
        int score;
        int func;
        int lat;
        int st;
        int n;
    } exp_t;

    exp_t exp_q[$];
    int   res_q[$];
    int   total = 0, bad = 0, cyc = 0, mon_cnt = 0;
    bit   finished = 0;
    int   bx[64];
    int   bc[64];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int got, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got %0d expected %0d", req, got, expv);
        end
    endtask

    function automatic int xf(input int f, input int x);
        case (f)
            0: return x;
            1: return (~x) & 255;
            2: return x >> 1;
            3: return x ^ 8'h55;
            4: return (x * 3) & 255;
            5: return ((x << 1) | (x >> 7)) & 255;
            default: return (x + 1) & 255;
        endcase
    endfunction

    task automatic load(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            ld_we = 1'b1; ld_addr = AW'(k); ld_value = DW'(bx[k]); ld_class = bc[k][0];
        end
        @(posedge clk); #1;
        ld_we = 1'b0;
    endtask

    // Driver: compute the expectation, queue it, start the run.
    task automatic run_case(input int n, input bit disturb);
        exp_t e;
        int gb, gt, gf, lat, want;
        gb = 2047; gt = 0; gf = 0; lat = 0;
        for (int f = 0; f < 7; f++) begin
            int fb, ft;
            fb = 2047; ft = 0;
            for (int j = 0; j < n; j++) begin
                int t, h1, h0, l1, l0, s;
                t = xf(f, bx[j]); h1 = 0; h0 = 0; l1 = 0; l0 = 0;
                for (int i = 0; i < n; i++) begin
                    if (xf(f, bx[i]) >= t) begin
                        if (bc[i] != 0) h1++; else h0++;
                    end else begin
                        if (bc[i] != 0) l1++; else l0++;
                    end
                end
                s = ((h1 < h0) ? h1 : h0) + ((l1 < l0) ? l1 : l0);
                if (s < fb) begin fb = s; ft = t; end
            end
            lat += 16 * n + n * (7 + 4 * n) + 1;
            if (fb < gb) begin gb = fb; gt = ft; gf = f; lat += n; end
        end
        for (int i = 0; i < n; i++) res_q.push_back(xf(gf, bx[i]));
        want = mon_cnt + 1;
        @(posedge clk); #1;
        n_samp = CW'(n); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        e.thr = gt; e.score = gb; e.func = gf; e.lat = lat; e.st = cyc; e.n = n;
        exp_q.push_back(e);
        chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
        if (disturb) begin
            repeat (40) @(posedge clk);
            #1;
            n_samp = CW'(3); start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
            chk(busy == 1'b1, "R9 busy kept after second start", int'(busy), 1);
        end
        wait (mon_cnt == want);
    endtask

    // Monitor: pop the expectation when done pulses and compare.
    initial begin
        forever begin
            @(posedge clk); #1;
            if (done && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(busy == 1'b0, "R8 busy low with done", int'(busy), 0);
                chk(cyc - e.st == e.lat, "R7 run length", cyc - e.st, e.lat);
                chk(int'(best_score) == e.score, "R3 R5 best score", int'(best_score), e.score);
                chk(int'(best_thr) == e.thr, "R4 R5 best threshold", int'(best_thr), e.thr);
                chk(int'(best_func) == e.func, "R2 R4 best function", int'(best_func), e.func);
                @(posedge clk); #1;
                chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
                for (int i = 0; i < e.n; i++) begin
                    int rv;
                    rv = res_q.pop_front();
                    rd_addr = AW'(i);
                    #1;
                    chk(int'(rd_data) == rv, "R6 result memory", int'(rd_data), rv);
                end
                chk(int'(best_score) == e.score, "R5 score held", int'(best_score), e.score);
                mon_cnt++;
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog got %0d expected %0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);
        chk(done == 1'b0, "R1 done reset", int'(done), 0);
        chk(int'(best_score) == 2047, "R1 score reset", int'(best_score), 2047);
        chk(int'(best_thr) == 0, "R1 thr reset", int'(best_thr), 0);
        chk(int'(best_func) == 0, "R1 func reset", int'(best_func), 0);

        // Single sample: every function ties at zero, function 0 kept (R4).
        bx[0] = 8'h3C; bc[0] = 1;
        load(1); run_case(1, 0);

        // Classes follow bit 6: the rotate function separates them (R2, R3).
        bx[0] = 8'h10; bc[0] = 0; bx[1] = 8'hC0; bc[1] = 1;
        bx[2] = 8'h40; bc[2] = 1; bx[3] = 8'h90; bc[3] = 0;
        bx[4] = 8'h70; bc[4] = 1; bx[5] = 8'hA5; bc[5] = 0;
        load(6); run_case(6, 0);

        // Equal values, mixed classes: all thresholds tie (R4).
        for (int k = 0; k < 8; k++) begin bx[k] = 8'h81; bc[k] = k % 3 == 0; end
        load(8); run_case(8, 0);

        // Pseudo-random sets of several sizes.
        seed = 12345;
        for (int k = 0; k < 16; k++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            bx[k] = (seed >> 8) & 255;
            bc[k] = (seed >> 20) & 1;
        end
        load(12); run_case(12, 0);

        // Same set, mid-run start and count change are ignored (R9, R10).
        run_case(10, 1);

        // Larger set with class tied to the low bit.
        for (int k = 0; k < 16; k++) bc[k] = bx[k] & 1;
        load(16); run_case(16, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule